// File: doc/BRIEF.md
# Raw Pixel Output Timing Generator

This block frames a stream of raw pixels for a progressive-scan image output. Each line period holds a run of active columns and then a programmable number of horizontal blanking cycles. Each frame holds the active rows and then a programmable number of blanking line periods. The generator issues a line-valid and a frame-valid flag, and a 10-bit data bus that carries the upstream pixel while the line is valid and zero everywhere else. It advances one pixel position per master clock cycle.

All outputs are registered on the rising master clock edge. A pixel clock that is derived from the master clock therefore has its falling edge half a master period after every data and framing transition, which places it mid-way between transitions. The pixel-clock-run output stays high on every enabled cycle, blanking included, so the derived clock never stops while the block streams. The block also gives a pulse at the end of each line period and a pulse at the end of each frame period. Geometry is held in shadow registers. These are loaded only at a frame boundary or while the block is disabled.

Top module: `rawpix_timing_gen`

## Requirements
- R1: Each frame has exactly H active rows. In each of them lineValid is high for exactly W consecutive cycles, and rows come out top to bottom with columns left to right. The first active pixel appears on the outputs one cycle after the first rising edge with enable high.
- R2: While lineValid is high, pixOut equals the pixIn value that was sampled at the previous rising edge. This gives exactly one pixel per clock.
- R3: Between two active rows, lineValid is low for exactly HB cycles. With HB = 0, lineValid stays high across row boundaries.
- R4: A line period is W+HB cycles and a frame period is (H+VB)·(W+HB) cycles. During the VB blanking line periods, lineValid and frameValid are both low.
- R5: frameValid rises together with the first lineValid of a frame and falls on the cycle after the last active pixel of the last row. lineValid is never high while frameValid is low.
- R6: pixOut is all zeros on every cycle in which lineValid is low.
- R7: pixClkRun is high on every output cycle that follows an enabled rising edge, blanking included, and low otherwise.
- R8: Geometry inputs are sampled only at a frame boundary, or while enable is low. A change made in the middle of a frame takes effect with the next frame.
- R9: lineEnd pulses for one cycle on the last cycle of every line period, including the vertical blanking line periods. frameEnd pulses on the last cycle of each frame period, always together with lineEnd.
- R10: After reset, and on the cycle after enable is sampled low, all outputs are zero. Enabling again restarts the frame at row 0, column 0.
- R11: A programmed active width or height of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Streaming enable; low holds the block at frame start |
| cfgWidth | input | 12 | Active columns per row (W) |
| cfgHeight | input | 12 | Active rows per frame (H) |
| cfgHBlank | input | 12 | Horizontal blanking cycles per line (HB) |
| cfgVBlank | input | 12 | Vertical blanking line periods per frame (VB) |
| pixIn | input | 10 | Upstream pixel value, sampled on active positions |
| lineValid | output | 1 | High on valid pixel positions |
| frameValid | output | 1 | High from first to last valid pixel of a frame |
| pixOut | output | 10 | Pixel data; zero outside valid positions |
| pixClkRun | output | 1 | Pixel clock enable, continuous while streaming |
| lineEnd | output | 1 | Last cycle of a line period |
| frameEnd | output | 1 | Last cycle of a frame period |

## Verification
The block is driven with a geometry that has both horizontal and vertical blanking, over three frames. This shows that rows, line periods and frame periods repeat correctly. A geometry with no blanking at all tells a continuous line-valid apart from a missing row boundary. A run of zero width and height shows that the clamp is in place. A geometry change made mid-frame shows that the shadow load happens at the frame boundary and not at once. Dropping enable mid-frame and raising it again shows that all outputs clear and the frame restarts from its first pixel.

// File: rtl/rawpix_pkg.sv
package rawpix_pkg;
  // Strobes handed from the position control to the output datapath
  typedef struct packed {
    logic running;   // block enabled this cycle
    logic active;    // current position is a valid pixel
    logic inFrame;   // current position lies inside the frame-valid span
    logic lineEnd;   // last position of a line period
    logic frameEnd;  // last position of a frame period
  } ctrlStrobes_t;
endpackage

// File: rtl/rawpix_ctrl.sv
module rawpix_ctrl
  import rawpix_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [COL_W-1:0] cfgWidth,
  input  logic [ROW_W-1:0] cfgHeight,
  input  logic [COL_W-1:0] cfgHBlank,
  input  logic [ROW_W-1:0] cfgVBlank,
  output ctrlStrobes_t     strobes
);
  localparam int LINE_W = COL_W + 1;
  localparam int FRM_W  = ROW_W + 1;

  logic [COL_W-1:0]  shWidth, shHBlank;
  logic [ROW_W-1:0]  shHeight, shVBlank;
  logic [LINE_W-1:0] colCnt, lineLen, colW;
  logic [FRM_W-1:0]  rowCnt, frameRows, rowH;
  logic lastCol, lastRow, wrap, loadCfg;

  function automatic logic [COL_W-1:0] clampCol(input logic [COL_W-1:0] v);
    return (v == '0) ? COL_W'(1) : v;
  endfunction
  function automatic logic [ROW_W-1:0] clampRow(input logic [ROW_W-1:0] v);
    return (v == '0) ? ROW_W'(1) : v;
  endfunction

  assign colW      = {1'b0, shWidth};
  assign rowH      = {1'b0, shHeight};
  assign lineLen   = colW + {1'b0, shHBlank};
  assign frameRows = rowH + {1'b0, shVBlank};
  assign lastCol   = (colCnt == lineLen - LINE_W'(1));
  assign lastRow   = (rowCnt == frameRows - FRM_W'(1));
  assign wrap      = enable && lastCol && lastRow;
  assign loadCfg   = !enable || wrap;

  // Shadow geometry: reloaded only at a frame boundary or while idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shWidth  <= COL_W'(1);
      shHeight <= ROW_W'(1);
      shHBlank <= '0;
      shVBlank <= '0;
    end else if (loadCfg) begin
      shWidth  <= clampCol(cfgWidth);
      shHeight <= clampRow(cfgHeight);
      shHBlank <= cfgHBlank;
      shVBlank <= cfgVBlank;
    end
  end

  // Raster position counters
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (lastCol) begin
      colCnt <= '0;
      rowCnt <= lastRow ? '0 : rowCnt + FRM_W'(1);
    end else begin
      colCnt <= colCnt + LINE_W'(1);
    end
  end

  always_comb begin
    strobes.running  = enable;
    strobes.active   = enable && (colCnt < colW) && (rowCnt < rowH);
    strobes.inFrame  = enable && (rowCnt < rowH) &&
                       !((rowCnt == rowH - FRM_W'(1)) && (colCnt >= colW));
    strobes.lineEnd  = enable && lastCol;
    strobes.frameEnd = wrap;
  end

  assert_col_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    colCnt < lineLen);
  assert_row_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    rowCnt < frameRows);
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !wrap) |=> ($stable(shWidth) && $stable(shHeight) &&
                           $stable(shHBlank) && $stable(shVBlank)));
  assert_active_in_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |-> strobes.inFrame);
endmodule

// File: rtl/rawpix_dpath.sv
module rawpix_dpath
  import rawpix_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] pixIn,
  output logic              lineValid,
  output logic              frameValid,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixClkRun,
  output logic              lineEnd,
  output logic              frameEnd
);
  // All outputs launch on the rising edge; a derived pixel clock falls mid-way
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid  <= 1'b0;
      frameValid <= 1'b0;
      pixOut     <= '0;
      pixClkRun  <= 1'b0;
      lineEnd    <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      lineValid  <= strobes.active;
      frameValid <= strobes.inFrame;
      pixOut     <= strobes.active ? pixIn : '0;
      pixClkRun  <= strobes.running;
      lineEnd    <= strobes.lineEnd;
      frameEnd   <= strobes.frameEnd;
    end
  end

  assert_zero_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lineValid |-> (pixOut == '0));
  assert_lv_within_fv_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> frameValid);
  assert_fv_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pixClkRun && $fell(frameValid)) |-> $past(lineValid));
  assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (pixOut == $past(pixIn)));
  assert_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.running |=> pixClkRun);
  assert_frame_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> lineEnd);
endmodule

// File: rtl/rawpix_timing_gen.sv
module rawpix_timing_gen
  import rawpix_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [COL_W-1:0]  cfgWidth,
  input  logic [ROW_W-1:0]  cfgHeight,
  input  logic [COL_W-1:0]  cfgHBlank,
  input  logic [ROW_W-1:0]  cfgVBlank,
  input  logic [DATA_W-1:0] pixIn,
  output logic              lineValid,
  output logic              frameValid,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixClkRun,
  output logic              lineEnd,
  output logic              frameEnd
);
  ctrlStrobes_t strobes;

  rawpix_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank),
    .strobes(strobes)
  );

  rawpix_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixIn(pixIn),
    .lineValid(lineValid), .frameValid(frameValid), .pixOut(pixOut),
    .pixClkRun(pixClkRun), .lineEnd(lineEnd), .frameEnd(frameEnd)
  );
endmodule

// File: tb/rawpix_timing_gen_test.sv
module rawpix_timing_gen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [11:0] cfgWidth = '0, cfgHeight = '0, cfgHBlank = '0, cfgVBlank = '0;
  logic [9:0] pixIn = '0;
  logic lineValid, frameValid, pixClkRun, lineEnd, frameEnd;
  logic [9:0] pixOut;

  int tests = 0;
  int fails = 0;
  int pixMis = 0;
  bit done = 0;

  bit lvA [0:1023];
  bit fvA [0:1023];
  bit leA [0:1023];
  bit feA [0:1023];
  bit runA[0:1023];

  always #10 clk = ~clk;  // 50 MHz

  rawpix_timing_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank), .pixIn(pixIn),
    .lineValid(lineValid), .frameValid(frameValid), .pixOut(pixOut),
    .pixClkRun(pixClkRun), .lineEnd(lineEnd), .frameEnd(frameEnd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int w, input int h, input int hb, input int vb);
    cfgWidth = 12'(w); cfgHeight = 12'(h); cfgHBlank = 12'(hb); cfgVBlank = 12'(vb);
  endtask

  // Record n output cycles from index 'from'; check data rules (R2, R6) per cycle
  task automatic capture(input int from, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lvA[from+i] = lineValid; fvA[from+i] = frameValid;
      leA[from+i] = lineEnd;   feA[from+i] = frameEnd; runA[from+i] = pixClkRun;
      if (lineValid && pixOut !== pixIn) pixMis++;
      if (!lineValid && pixOut !== 10'd0) pixMis++;
      pixIn = 10'((int'(pixIn) * 5 + 113 + i) & 1023);
    end
  endtask

  // Compare recorded indices [from,to) with the raster expected from W,H,HB,VB
  task automatic checkSeg(input string tag, input int from, input int to, input int base,
                          input int w, input int h, input int hb, input int vb);
    int L = w + hb;
    int per = L * (h + vb);
    int mLv = -1, mFv = -1, mLe = -1, mFe = -1, mRun = -1;
    for (int i = from; i < to; i++) begin
      int p = (i - base) % per;
      int c = p % L;
      int r = p / L;
      bit eLv = (c < w) && (r < h);
      bit eFv = (r < h) && !((r == h - 1) && (c >= w));
      bit eLe = (c == L - 1);
      bit eFe = (p == per - 1);
      if (lvA[i] != eLv && mLv < 0) mLv = i;
      if (fvA[i] != eFv && mFv < 0) mFv = i;
      if (leA[i] != eLe && mLe < 0) mLe = i;
      if (feA[i] != eFe && mFe < 0) mFe = i;
      if (runA[i] != 1'b1 && mRun < 0) mRun = i;
    end
    check(mLv < 0, {tag, " R1 R3 R4 lineValid first bad index"}, mLv, -1);
    check(mFv < 0, {tag, " R5 frameValid first bad index"}, mFv, -1);
    check(mLe < 0, {tag, " R9 lineEnd first bad index"}, mLe, -1);
    check(mFe < 0, {tag, " R9 frameEnd first bad index"}, mFe, -1);
    check(mRun < 0, {tag, " R7 pixClkRun first bad index"}, mRun, -1);
  endtask

  task automatic idle(input int n);
    enable = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check({lineValid, frameValid, pixClkRun, lineEnd, frameEnd} == 5'b0 && pixOut == 10'd0,
          "R10 reset outputs", {lineValid, frameValid, pixClkRun, lineEnd, frameEnd}, 0);
  endtask

  task automatic testBasic();
    setCfg(8, 4, 3, 2); idle(2);
    pixMis = 0; enable = 1'b1;
    capture(0, 198);  // three frames of 66 cycles
    checkSeg("basic", 0, 198, 0, 8, 4, 3, 2);
    check(pixMis == 0, "R2 R6 basic data mismatches", pixMis, 0);
  endtask

  task automatic testNoBlank();
    setCfg(5, 3, 0, 0); idle(2);
    pixMis = 0; enable = 1'b1;
    capture(0, 45);
    checkSeg("noblank", 0, 45, 0, 5, 3, 0, 0);
    check(pixMis == 0, "R2 R6 noblank data mismatches", pixMis, 0);
  endtask

  task automatic testMidChange();
    setCfg(6, 3, 2, 1); idle(2);
    pixMis = 0; enable = 1'b1;
    capture(0, 10);
    setCfg(4, 2, 1, 2);   // period A = 32, period B = 20
    capture(10, 72);
    checkSeg("R8 before", 0, 32, 0, 6, 3, 2, 1);
    checkSeg("R8 after", 32, 72, 32, 4, 2, 1, 2);
    check(pixMis == 0, "R8 data mismatches", pixMis, 0);
  endtask

  task automatic testZeroSize();
    setCfg(0, 0, 2, 1); idle(2);
    pixMis = 0; enable = 1'b1;
    capture(0, 18);
    checkSeg("R11 zero", 0, 18, 0, 1, 1, 2, 1);
    check(pixMis == 0, "R11 data mismatches", pixMis, 0);
  endtask

  task automatic testEnableDrop();
    setCfg(8, 4, 3, 2); idle(2);
    pixMis = 0; enable = 1'b1;
    capture(0, 20);
    enable = 1'b0;
    capture(20, 3);
    for (int i = 20; i < 23; i++)
      check({lvA[i], fvA[i], leA[i], feA[i], runA[i]} == 5'b0, "R10 disabled outputs",
            {lvA[i], fvA[i], leA[i], feA[i], runA[i]}, 0);
    enable = 1'b1;
    capture(23, 70);
    checkSeg("R10 restart", 23, 93, 23, 8, 4, 3, 2);
    check(pixMis == 0, "R6 R10 data mismatches", pixMis, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testNoBlank();
    testMidChange();
    testZeroSize();
    testEnableDrop();
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule